// File: doc/BRIEF.md
# Chip-Select Memory Access Controller

This block runs external memory cycles for an internal bus master. It holds a small set of programmable banks. Each bank has a base address, a base address type and a mask for each. It also has a wait-state count, a port width and a valid flag. When an access starts, the block compares the upper address bits and the address type against every valid bank. It then runs one generic cycle on the winning bank's chip select. During that cycle it drives output enable for reads or per-lane write enables for writes. After the programmed number of wait states it pulses a transfer acknowledge back to the master.

An access can start from the internal request strobe or from a memory-transfer-start input. The second path lets an external master borrow the chip selects and cycle timing. Bank settings are written through a plain register port. After reset, bank 0 matches every address, uses a 16-bit port and the longest wait count, so boot memory can be reached before any setup.

Top module: `csm_ctrl`

## Requirements
- R1: A bank hits only when address bits [31:15] equal its 17-bit base in every position where its 17-bit address mask holds a 1. Positions where the mask holds a 0 are not compared.
- R2: The 3-bit address type must also equal the bank's base type in every position set in its 3-bit type mask. A bank hits only if both compares succeed.
- R3: Only banks whose valid flag is set take part in the match. When several valid banks hit, the lowest-numbered bank wins.
- R4: When no valid bank hits, no chip select asserts and no acknowledge is generated. The controller is then ready for the next start.
- R5: Chip select and its strobes assert in the first cycle after the start is sampled and stay asserted for N+1 cycles, where N (0 to 30) is the bank's wait count. They drop in the cycle in which `ta` is high, and `ta` is high for that single cycle.
- R6: On a read (`req_write`=0), `oe` is high for the whole cycle and all `we` lanes are low.
- R7: On a write, `we` equals `req_be`, where bit 3 is data[31:24] and bit 0 is data[7:0]. On a bank set to a 16-bit port, lanes 1 and 0 are forced low and `oe` stays low.
- R8: A pulse on `ext_mts` starts an access exactly as `req_valid` does, using the same address, type, direction and lane inputs.
- R9: A start that arrives while an access is in progress is ignored. The running chip select is held unchanged and no second cycle follows.
- R10: After reset all outputs are low. Bank 0 is valid with all masks cleared, a 16-bit port and 30 wait states. Banks 1 and up are invalid.
- R11: The register port selects the bank with `cfg_addr[2:1]` and the word with `cfg_addr[0]`. Word 0 holds base [16:0], base type [22:20] and valid [31]. Word 1 holds address mask [16:0], type mask [22:20], wait count [28:24] and 16-bit port [30]. A write applies to the next access that starts and never to one already running.
- R12: At most one chip select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Bank index and word select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Internal master access start |
| ext_mts | input | 1 | External master access start |
| req_addr | input | 32 | Access address |
| req_type | input | 3 | Access address type |
| req_write | input | 1 | 1 for write, 0 for read |
| req_be | input | 4 | Byte lanes written |
| cs | output | 4 | Chip selects, one per bank |
| oe | output | 1 | Output enable for reads |
| we | output | 4 | Per-lane write enables |
| ta | output | 1 | Transfer acknowledge pulse |

## Verification
The bench sets up two banks with the same base and overlapping address ranges. This checks that the lower-numbered bank wins and that a type mismatch pushes the access to the next bank. A decoder that searched from the top, or that ignored the type, would assert the wrong chip select. Separate cases cover a masked-off address bit, an invalid bank whose base matches, and an address that no bank covers. A wrong mask polarity, a missing valid check, or an acknowledge on a miss would each show up at `cs` or `ta`. Cycle lengths are counted at 0, 2, 4, 7 and 30 wait states, which catches off-by-one errors in the counter. Further cases cover a second start during a busy cycle, a register rewrite in the middle of a cycle, and writes to a 16-bit port. These would catch a machine that restarts, one that reads the live wait count, or one that leaves the low lanes enabled.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int CMP_W  = 17;
  localparam int TYPE_W = 3;
  localparam int WS_W   = 5;
  localparam int LANES  = 4;
  localparam int MAX_WS = 30;

  typedef struct packed {
    logic              valid;
    logic [TYPE_W-1:0] btype;
    logic [CMP_W-1:0]  base;
    logic [CMP_W-1:0]  amask;
    logic [TYPE_W-1:0] tmask;
    logic [WS_W-1:0]   waits;
    logic              port16;
  } bank_cfg_t;
endpackage

// File: rtl/csm_bank_regs.sv
module csm_bank_regs
  import csm_pkg::*;
#(
  parameter int NB     = 4,
  parameter int DATA_W = 32,
  localparam int BI_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [BI_W:0]        cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output bank_cfg_t [NB-1:0]   cfg_o
);
  // Boot settings of bank 0: open decode, narrow port, slowest timing.
  localparam bank_cfg_t BOOT_CFG = '{
    valid: 1'b1, btype: '0, base: '0, amask: '0, tmask: '0,
    waits: WS_W'(MAX_WS), port16: 1'b1};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[b] <= (b == 0) ? BOOT_CFG : '0;
      end else if (cfg_we && cfg_addr[BI_W:1] == BI_W'(b)) begin
        if (!cfg_addr[0]) begin
          cfg_o[b].base  <= cfg_wdata[CMP_W-1:0];
          cfg_o[b].btype <= cfg_wdata[20 +: TYPE_W];
          cfg_o[b].valid <= cfg_wdata[31];
        end else begin
          cfg_o[b].amask  <= cfg_wdata[CMP_W-1:0];
          cfg_o[b].tmask  <= cfg_wdata[20 +: TYPE_W];
          cfg_o[b].waits  <= cfg_wdata[24 +: WS_W];
          cfg_o[b].port16 <= cfg_wdata[30];
        end
      end
    end
  end
endmodule

// File: rtl/csm_decode.sv
module csm_decode
  import csm_pkg::*;
#(
  parameter int NB    = 4,
  localparam int BI_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  bank_cfg_t [NB-1:0] cfg_i,
  input  logic [CMP_W-1:0]   addr_i,
  input  logic [TYPE_W-1:0]  type_i,
  output logic               hit_o,
  output logic [BI_W-1:0]    idx_o
);
  logic [NB-1:0] match;

  for (genvar b = 0; b < NB; b++) begin : g_cmp
    logic a_ok, t_ok;
    assign a_ok = ((addr_i ^ cfg_i[b].base)  & cfg_i[b].amask) == '0;
    assign t_ok = ((type_i ^ cfg_i[b].btype) & cfg_i[b].tmask) == '0;
    assign match[b] = cfg_i[b].valid && a_ok && t_ok;
  end

  // Scan from the top so the lowest matching index is the last to win.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = BI_W'(i);
      end
    end
  end
endmodule

// File: rtl/csm_cycle.sv
module csm_cycle
  import csm_pkg::*;
#(
  parameter int NB    = 4,
  localparam int BI_W = (NB > 1) ? $clog2(NB) : 1,
  localparam logic [LANES-1:0] NARROW_LANES =
    {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             hit_i,
  input  logic [BI_W-1:0]  idx_i,
  input  logic [WS_W-1:0]  waits_i,
  input  logic             port16_i,
  input  logic             write_i,
  input  logic [LANES-1:0] be_i,
  output logic [NB-1:0]    cs_o,
  output logic             oe_o,
  output logic [LANES-1:0] we_o,
  output logic             ta_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_t;
  st_t             st;
  logic [WS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      cs_o <= '0;
      oe_o <= 1'b0;
      we_o <= '0;
      ta_o <= 1'b0;
    end else begin
      ta_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i && hit_i) begin
            st   <= ST_RUN;
            cnt  <= waits_i;
            cs_o <= NB'(1) << idx_i;
            oe_o <= !write_i;
            we_o <= write_i ? (port16_i ? (be_i & NARROW_LANES) : be_i) : '0;
          end
        end
        ST_RUN: begin
          if (cnt == '0) begin
            st   <= ST_IDLE;
            cs_o <= '0;
            oe_o <= 1'b0;
            we_o <= '0;
            ta_o <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csm_ctrl.sv
module csm_ctrl
  import csm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  localparam int BI_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [BI_W:0]        cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 req_valid,
  input  logic                 ext_mts,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [TYPE_W-1:0]    req_type,
  input  logic                 req_write,
  input  logic [LANES-1:0]     req_be,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 oe,
  output logic [LANES-1:0]     we,
  output logic                 ta
);
  bank_cfg_t [NUM_BANKS-1:0] cfg;
  logic                      hit;
  logic [BI_W-1:0]           idx;

  csm_bank_regs #(.NB(NUM_BANKS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_o(cfg));

  csm_decode #(.NB(NUM_BANKS)) u_dec (
    .cfg_i(cfg), .addr_i(req_addr[ADDR_W-1 -: CMP_W]), .type_i(req_type),
    .hit_o(hit), .idx_o(idx));

  csm_cycle #(.NB(NUM_BANKS)) u_cyc (
    .clk(clk), .rst(rst), .start_i(req_valid | ext_mts), .hit_i(hit),
    .idx_i(idx), .waits_i(cfg[idx].waits), .port16_i(cfg[idx].port16),
    .write_i(req_write), .be_i(req_be),
    .cs_o(cs), .oe_o(oe), .we_o(we), .ta_o(ta));
endmodule

// File: rtl/csm_ctrl_chk.sv
module csm_ctrl_chk
  import csm_pkg::*;
#(
  parameter int NB = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NB-1:0]    cs,
  input logic             oe,
  input logic [LANES-1:0] we,
  input logic             ta
);
  logic [5:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || cs == '0) run_len <= '0;
    else if (run_len != 6'h3f) run_len <= run_len + 1'b1;
  end

  assert_cs_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs));
  assert_ta_single_R5: assert property (@(posedge clk) disable iff (rst)
    ta |=> !ta);
  assert_ta_ends_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    ta |-> (cs == '0 && $past(cs) != '0));
  assert_strobe_needs_cs_R5: assert property (@(posedge clk) disable iff (rst)
    (oe || we != '0) |-> cs != '0);
  assert_read_no_we_R6: assert property (@(posedge clk) disable iff (rst)
    oe |-> we == '0);
  assert_cs_held_R9: assert property (@(posedge clk) disable iff (rst)
    (cs != '0) |=> (ta || $stable(cs)));
  assert_max_length_R5: assert property (@(posedge clk) disable iff (rst)
    run_len <= 6'(MAX_WS + 1));
endmodule

bind csm_ctrl csm_ctrl_chk #(.NB(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .oe(oe), .we(we), .ta(ta));

// File: tb/csm_ctrl_tb.sv
`timescale 1ns/1ps
module csm_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, ext_mts = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_type = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_be = '0;
  logic [3:0]  cs;
  logic        oe;
  logic [3:0]  we;
  logic        ta;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csm_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .ext_mts(ext_mts),
    .req_addr(req_addr), .req_type(req_type), .req_write(req_write),
    .req_be(req_be), .cs(cs), .oe(oe), .we(we), .ta(ta));

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  typ;
    logic        wr;
    logic [3:0]  be;
    logic        mts;
    logic [2:0]  bank;   // 7 = no hit expected
    logic [4:0]  ws;
    logic [3:0]  ewe;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_4000, 3'd0, 1'b0, 4'h0, 1'b0, 3'd0, 5'd2, 4'h0}, // R6 read bank0
    '{32'h0000_4000, 3'd0, 1'b1, 4'hF, 1'b0, 3'd0, 5'd2, 4'hC}, // R7 16-bit lanes
    '{32'h0001_0000, 3'd5, 1'b1, 4'h3, 1'b0, 3'd1, 5'd0, 4'h3}, // R3 priority
    '{32'h0001_8000, 3'd1, 1'b0, 4'h0, 1'b0, 3'd2, 5'd4, 4'h0}, // R1 masked bit, R2
    '{32'h0001_8000, 3'd5, 1'b1, 4'h5, 1'b1, 3'd1, 5'd0, 4'h5}, // R8 ext start
    '{32'h8000_0000, 3'd2, 1'b0, 4'h0, 1'b0, 3'd7, 5'd0, 4'h0}, // R3 invalid bank
    '{32'h0002_0000, 3'd0, 1'b1, 4'hF, 1'b0, 3'd7, 5'd0, 4'h0}, // R4 no hit
    '{32'h0001_0004, 3'd7, 1'b1, 4'hA, 1'b0, 3'd2, 5'd4, 4'hA}  // R2 type miss
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int bank, input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {2'(bank), sel}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] w_base(bit v, logic [2:0] t, logic [16:0] b);
    return {v, 8'd0, t, 3'd0, b};
  endfunction

  function automatic logic [31:0] w_opt(logic [16:0] m, logic [2:0] tm,
                                        logic [4:0] ws, bit p16);
    return {1'b0, p16, 1'b0, ws, 1'b0, tm, 3'd0, m};
  endfunction

  // Issues one start, then checks the chip select, the strobes and the cycle length.
  task automatic access(input vec_t v, input string req);
    logic [3:0] ecs;
    int n;
    ecs = (v.bank == 3'd7) ? 4'h0 : (4'h1 << v.bank);
    @(negedge clk);
    req_addr = v.addr; req_type = v.typ; req_write = v.wr; req_be = v.be;
    req_valid = !v.mts; ext_mts = v.mts;
    @(negedge clk);
    req_valid = 1'b0; ext_mts = 1'b0;
    check(cs == ecs, {req, " cs"}, cs, ecs);
    check(oe == (!v.wr && ecs != 0), {req, " oe"}, oe, (!v.wr && ecs != 0));
    check(we == (v.wr ? v.ewe : 4'h0), {req, " we"}, we, (v.wr ? v.ewe : 4'h0));
    if (ecs == 0) begin
      n = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (ta || cs != 0) n++;
      end
      check(n == 0, {req, " R4 no ack"}, n, 0);
    end else begin
      n = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (ta) break;
        if (cs == ecs) n++;
      end
      check(ta && cs == 0, {req, " R5 ta with cs low"}, {ta, cs}, 5'h10);
      check(n == int'(v.ws) + 1, {req, " R5 length"}, n, int'(v.ws) + 1);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({cs, oe, we, ta} == 0, "R10 outputs in reset", {cs, oe, we, ta}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({cs, oe, we, ta} == 0, "R10 outputs after reset", {cs, oe, we, ta}, 0);
    // Boot bank matches any address, 30 waits, 16-bit port.
    access('{32'h1234_5678, 3'd3, 1'b1, 4'hF, 1'b0, 3'd0, 5'd30, 4'hC}, "R10 boot");
    access('{32'hFFFF_0000, 3'd6, 1'b0, 4'h0, 1'b0, 3'd0, 5'd30, 4'h0}, "R10 boot read");

    // R11 programming of all four banks.
    cfg_write(0, 1'b0, w_base(1'b1, 3'd0, 17'h00000));
    cfg_write(0, 1'b1, w_opt(17'h1FFFF, 3'd0, 5'd2, 1'b1));
    cfg_write(1, 1'b0, w_base(1'b1, 3'd5, 17'h00002));
    cfg_write(1, 1'b1, w_opt(17'h1FFFE, 3'd7, 5'd0, 1'b0));
    cfg_write(2, 1'b0, w_base(1'b1, 3'd0, 17'h00002));
    cfg_write(2, 1'b1, w_opt(17'h1FFFE, 3'd0, 5'd4, 1'b0));
    cfg_write(3, 1'b0, w_base(1'b0, 3'd0, 17'h10000));
    cfg_write(3, 1'b1, w_opt(17'h1FFFF, 3'd0, 5'd7, 1'b0));

    for (int i = 0; i < NV; i++) access(VEC[i], $sformatf("vec%0d R1 R2 R3", i));

    // R11: validate bank 3, then rewrite its wait count during a running access.
    cfg_write(3, 1'b0, w_base(1'b1, 3'd0, 17'h10000));
    fork
      access('{32'h8000_0010, 3'd2, 1'b0, 4'h0, 1'b0, 3'd3, 5'd7, 4'h0}, "R11 old waits");
      begin
        repeat (3) @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {2'd3, 1'b1};
        cfg_wdata = w_opt(17'h1FFFF, 3'd0, 5'd1, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    access('{32'h8000_0010, 3'd2, 1'b1, 4'h9, 1'b0, 3'd3, 5'd1, 4'h9}, "R11 new waits");

    // R9: a second start during a busy cycle is ignored.
    fork
      access('{32'h0001_0000, 3'd0, 1'b0, 4'h0, 1'b0, 3'd2, 5'd4, 4'h0}, "R9 busy start");
      begin
        repeat (3) @(negedge clk);
        req_addr = 32'h0000_0000; req_type = 3'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (cs != 0 || ta) extra++;
      end
      check(extra == 0, "R9 no second cycle", extra, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule